// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This block multiplies two 32-bit operands and folds the 64-bit product into a 64-bit accumulator held as two 32-bit words, HI (upper half) and LO (lower half). An instruction arrives as two operands plus two decoded fields: a 6-bit function code that picks signed or unsigned arithmetic, and a 5-bit modifier. The modifier picks whether the accumulator restarts from zero or keeps its old value, whether the product is added or subtracted, and whether the destination gets the upper or the lower half of the new accumulator. Sixteen variants come from these controls.

Instructions enter on a valid/ready handshake. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. One cycle later the destination word appears on `res_data` with `res_valid`. The result stays held until `res_ready` is seen high. While a result waits, `in_ready` is low, so back-pressure stops new instructions at the input. Undefined codes are not turned into results: they pulse `illegal_op`.

Software-visible HI and LO can be read at any time on `hi_q` and `lo_q`. They can be loaded directly through a write-enable per word.

Top module: `mac_unit`

## Requirements
- R1: After reset `res_valid` and `illegal_op` are 0 and both `hi_q` and `lo_q` are 0.
- R2: An instruction is legal when `funct` is 6'b011000 or 6'b011001 and `modif[0]`=1 and `modif[4]`=0. An accepted illegal instruction raises `illegal_op` for exactly the following cycle, produces no `res_valid`, and leaves HI and LO unchanged.
- R3: `funct[0]`=0 multiplies both operands as signed two's-complement values; `funct[0]`=1 multiplies them as unsigned values. In both cases the full 64-bit product is used.
- R4: `modif[2]`=0 starts the accumulator from zero; `modif[2]`=1 starts from the current {HI,LO}.
- R5: `modif[1]`=0 adds the product to the start value; `modif[1]`=1 subtracts it.
- R6: `modif[3]`=1 returns the new HI word on `res_data`; `modif[3]`=0 returns the new LO word.
- R7: All accumulator arithmetic wraps modulo 2^64 and raises no flag.
- R8: A legal instruction accepted at edge k updates `hi_q`/`lo_q` and asserts `res_valid` with its `res_data` at the same edge k. These values are visible in the following cycle.
- R9: `in_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold steady and no instruction is taken.
- R10: `hi_we`/`lo_we` load `wr_word` into HI/LO at the next edge. If a legal instruction is accepted in the same cycle, the instruction's update wins and the direct write is dropped.
- R11: `hi_q` and `lo_q` always show the current accumulator halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| funct | input | 6 | Function code, bit 0 selects unsigned |
| modif | input | 5 | Modifier: bit1 negate, bit2 accumulate, bit3 high half |
| res_valid | output | 1 | Destination word valid |
| res_ready | input | 1 | Consumer takes the destination word |
| res_data | output | 32 | Destination word |
| illegal_op | output | 1 | One-cycle pulse for a rejected code |
| hi_we | input | 1 | Direct HI write enable |
| lo_we | input | 1 | Direct LO write enable |
| wr_word | input | 32 | Direct write data |
| hi_q | output | 32 | Current HI word |
| lo_q | output | 32 | Current LO word |

## Verification
A wrong accumulator shows up on `hi_q`/`lo_q` in the cycle after the faulty update. It also shows on the next accumulate-variant result, so chained accumulate instructions expose a stale or misrouted half within one instruction. A decode fault shows at once on `res_data`, for example through a wrong sign extension, a sign flip or the wrong half. An illegal code that leaks shows on `illegal_op`, or as a change on `hi_q`/`lo_q` one cycle later. Stalling the consumer shows whether held results or accumulator state drift during back-pressure.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int XLEN = 32;
  localparam int ALEN = 2 * XLEN;
  localparam logic [5:0] FN_SMUL = 6'b011000;
  localparam logic [5:0] FN_UMUL = 6'b011001;

  typedef struct packed {
    logic legal;
    logic is_unsigned;
    logic negate;
    logic accumulate;
    logic pick_high;
  } mac_ctl_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [5:0] funct,
  input  logic [4:0] modif,
  output mac_ctl_t   ctl
);
  logic fn_ok;
  logic md_ok;

  always_comb begin
    fn_ok = (funct == FN_SMUL) || (funct == FN_UMUL);
    md_ok = modif[0] && !modif[4];
    ctl.legal       = fn_ok && md_ok;
    ctl.is_unsigned = funct[0];
    ctl.negate      = modif[1];
    ctl.accumulate  = modif[2];
    ctl.pick_high   = modif[3];
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  mac_ctl_t       ctl,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           hi_we,
  input  logic           lo_we,
  input  logic [W-1:0]   wr_word,
  output logic [2*W-1:0] acc_next,
  output logic [W-1:0]   hi_q,
  output logic [W-1:0]   lo_q
);
  localparam int AW = 2 * W;

  logic [AW-1:0] a_ext, b_ext, prod, base, acc;
  logic          upd;

  always_comb begin
    a_ext = ctl.is_unsigned ? {{W{1'b0}}, a} : {{W{a[W-1]}}, a};
    b_ext = ctl.is_unsigned ? {{W{1'b0}}, b} : {{W{b[W-1]}}, b};
    prod  = a_ext * b_ext;
    base  = ctl.accumulate ? acc : '0;
    acc_next = ctl.negate ? (base - prod) : (base + prod);
    upd   = fire && ctl.legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (upd) begin
      acc <= acc_next;
    end else begin
      if (hi_we) acc[AW-1:W] <= wr_word;
      if (lo_we) acc[W-1:0]  <= wr_word;
    end
  end

  assign hi_q = acc[AW-1:W];
  assign lo_q = acc[W-1:0];

  // R2
  illegal_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl.legal && !hi_we && !lo_we) |=> ($stable(hi_q) && $stable(lo_q)));
  // R4
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ctl.accumulate && (a == '0)) |=> (hi_q == '0 && lo_q == '0));
  // R10
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && hi_we) |=> (hi_q == $past(wr_word)));
endmodule

// File: rtl/mac_out_stage.sv
module mac_out_stage
  import mac_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         legal,
  input  logic         pick_high,
  input  logic [2*W-1:0] acc_next,
  input  logic         res_ready,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         illegal_op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      illegal_op <= 1'b0;
    end else begin
      illegal_op <= fire && !legal;
      if (fire) begin
        res_valid <= legal;
        if (legal) res_data <= pick_high ? acc_next[2*W-1:W] : acc_next[W-1:0];
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  // R2
  illegal_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !res_valid);
  // R8
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal) |=> res_valid);
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [5:0]  funct,
  input  logic [4:0]  modif,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_data,
  output logic        illegal_op,
  input  logic        hi_we,
  input  logic        lo_we,
  input  logic [31:0] wr_word,
  output logic [31:0] hi_q,
  output logic [31:0] lo_q
);
  mac_ctl_t        ctl;
  logic            fire;
  logic [ALEN-1:0] acc_next;

  assign in_ready = !res_valid || res_ready;
  assign fire     = in_valid && in_ready;

  mac_decode u_dec (.funct(funct), .modif(modif), .ctl(ctl));

  mac_datapath #(.W(XLEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ctl(ctl),
    .a(opnd_a), .b(opnd_b), .hi_we(hi_we), .lo_we(lo_we), .wr_word(wr_word),
    .acc_next(acc_next), .hi_q(hi_q), .lo_q(lo_q));

  mac_out_stage #(.W(XLEN)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .legal(ctl.legal),
    .pick_high(ctl.pick_high), .acc_next(acc_next), .res_ready(res_ready),
    .res_valid(res_valid), .res_data(res_data), .illegal_op(illegal_op));

  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> ($stable(hi_q) && $stable(lo_q)) || $past(hi_we || lo_we));
  // R6
  result_matches_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.legal) |=> (res_data == ($past(modif[3]) ? hi_q : lo_q)));
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, res_valid, res_ready = 1, illegal_op;
  logic [31:0] opnd_a = 0, opnd_b = 0, res_data, wr_word = 0, hi_q, lo_q;
  logic [5:0] funct = 0;
  logic [4:0] modif = 0;
  logic hi_we = 0, lo_we = 0;
  int n_run = 0, n_fail = 0;
  logic [63:0] m_acc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mac_unit i_mac_unit (.*);

  function automatic logic [63:0] model(logic [63:0] acc, logic [31:0] a, logic [31:0] b,
                                        logic [5:0] f, logic [4:0] m);
    logic [63:0] ea, eb, p, s;
    ea = f[0] ? {32'd0, a} : {{32{a[31]}}, a};
    eb = f[0] ? {32'd0, b} : {{32{b[31]}}, b};
    p = ea * eb;
    s = m[2] ? acc : 64'd0;
    return m[1] ? s - p : s + p;
  endfunction

  function automatic bit is_legal(logic [5:0] f, logic [4:0] m);
    return (f == 6'b011000 || f == 6'b011001) && m[0] && !m[4];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] a, logic [31:0] b, logic [5:0] f, logic [4:0] m, string req);
    logic [31:0] exp_res;
    bit lg;
    lg = is_legal(f, m);
    opnd_a = a; opnd_b = b; funct = f; modif = m; in_valid = 1; res_ready = 1;
    @(negedge clk);
    in_valid = 0;
    if (lg) begin
      m_acc = model(m_acc, a, b, f, m);
      exp_res = m[3] ? m_acc[63:32] : m_acc[31:0];
      chk({req, " res_valid"}, res_valid, 1);
      chk({req, " res_data"}, res_data, exp_res);
    end else begin
      chk({req, " R2 no result"}, res_valid, 0);
      chk({req, " R2 illegal_op"}, illegal_op, 1);
    end
    chk({req, " R11 hi"}, hi_q, m_acc[63:32]);
    chk({req, " R11 lo"}, lo_q, m_acc[31:0]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", res_valid, 0);
    chk("R1 illegal_op", illegal_op, 0);
    chk("R1 hi", hi_q, 0);
    chk("R1 lo", lo_q, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 signed vs unsigned, R6 half select, R8 latency
    issue(32'hFFFFFFFF, 32'hFFFFFFFF, 6'b011000, 5'b00001, "R3 R8 signed -1*-1 lo");
    issue(32'hFFFFFFFF, 32'hFFFFFFFF, 6'b011001, 5'b01001, "R3 R6 unsigned max hi");
    chk("R3 unsigned product", {hi_q, lo_q}, 64'hFFFFFFFE00000001);
    issue(32'h80000000, 32'h00000002, 6'b011000, 5'b01001, "R3 R6 signed min hi");
    chk("R3 signed hi word", hi_q, 32'hFFFFFFFF);
    // R5 negate
    issue(32'd3, 32'd5, 6'b011000, 5'b00011, "R5 negate lo");
    chk("R5 -15", {hi_q, lo_q}, -64'sd15);
    // R4 accumulate, R5 subtract-accumulate
    issue(32'd10, 32'd10, 6'b011000, 5'b00101, "R4 accumulate");
    chk("R4 85", {hi_q, lo_q}, 64'd85);
    issue(32'd5, 32'd17, 6'b011001, 5'b01111, "R5 sub-accumulate hi");
    chk("R5 0", {hi_q, lo_q}, 64'd0);
    // R7 wrap
    hi_we = 1; lo_we = 1; wr_word = 32'hFFFFFFFF; @(negedge clk); hi_we = 0; lo_we = 0;
    m_acc = 64'hFFFFFFFFFFFFFFFF;
    chk("R10 direct write", {hi_q, lo_q}, m_acc);
    issue(32'd2, 32'd1, 6'b011001, 5'b00101, "R7 wrap add");
    chk("R7 wrapped", {hi_q, lo_q}, 64'd1);
    issue(32'd2, 32'd1, 6'b011001, 5'b00111, "R7 wrap sub");
    chk("R7 wrapped under", {hi_q, lo_q}, 64'hFFFFFFFFFFFFFFFF);
    // R2 illegal codes
    issue(32'd7, 32'd7, 6'b011010, 5'b00001, "R2 bad funct");
    issue(32'd7, 32'd7, 6'b011000, 5'b00000, "R2 bad modif bit0");
    issue(32'd7, 32'd7, 6'b011001, 5'b10101, "R2 bad modif bit4");
    @(negedge clk);
    chk("R2 pulse one cycle", illegal_op, 0);
    // R10 priority: op wins over direct write
    hi_we = 1; lo_we = 1; wr_word = 32'h12345678;
    issue(32'd4, 32'd4, 6'b011000, 5'b00001, "R10 op priority");
    hi_we = 0; lo_we = 0;
    // R9 back-pressure
    res_ready = 0;
    opnd_a = 32'd9; opnd_b = 32'd9; funct = 6'b011000; modif = 5'b00101; in_valid = 1;
    #1 chk("R9 in_ready low", in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R9 held valid", res_valid, 1);
    chk("R9 held data", res_data, 32'd16);
    chk("R9 acc untouched", {hi_q, lo_q}, m_acc);
    in_valid = 0; res_ready = 1;
    #1 chk("R9 in_ready high", in_ready, 1);
    @(negedge clk);
    chk("R9 drained", res_valid, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] f;
      logic [4:0] m;
      int sel;
      sel = $urandom_range(0, 9);
      f = (sel == 0) ? 6'($urandom) : (sel < 5 ? 6'b011000 : 6'b011001);
      m = (sel == 1) ? 5'($urandom) : {1'b0, 3'($urandom), 1'b1};
      issue($urandom, (sel == 2) ? 32'hFFFFFFFF : $urandom, f, m, "R3 R4 R5 R6 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule